// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block converts a page (row) address and an optional column address into the ordered run of address-latch bytes that a NAND flash device expects. A single start pulse captures the request. The block then presents the bytes one at a time on a valid/ready output, and a downstream pin sequencer drives them onto the flash bus.

Transfers always cover whole pages, so any column bytes are sent as zero. The number of column bytes follows the page size. The number of row bytes follows the device capacity, and the capacity that calls for a third row byte is lower for small-page parts than for large-page parts. The final byte of every sequence carries a last marker. One clock after that byte is accepted, a done pulse tells the caller that the address phase is over.

Top module: `nand_addr_gen`

## Requirements
- R1: After reset, out_valid, out_last and done are low.
- R2: With col_en high, the sequence starts with zero-valued column bytes: one byte when big_page is 0 (512-byte pages) and two bytes when big_page is 1.
- R3: With row_en high, the row bytes follow the column bytes in least significant order: row_addr[7:0], then [15:8], then [23:16] when a third byte is needed.
- R4: With big_page=1, three row bytes are sent when the capacity 2^size_log2 MiB is at least 256 MiB (size_log2 >= 8), and two otherwise.
- R5: With big_page=0, three row bytes are sent when the capacity is at least 64 MiB (size_log2 >= 6), and two otherwise.
- R6: With row_en low and col_en high, only column bytes are sent, and out_last is high on the last column byte.
- R7: With row_en high, out_last is high on the final row byte and low on every earlier byte.
- R8: With col_en and row_en both low, a start produces no output byte and a done pulse on the following clock.
- R9: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values into the next cycle.
- R10: done is high for exactly the one clock after the final byte is accepted, and out_valid is low in that clock.
- R11: A start that arrives while a sequence is in progress is ignored, and the sequence in flight continues with its original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse; captures the fields below |
| col_en | input | 1 | Column bytes requested |
| row_en | input | 1 | Row bytes requested |
| big_page | input | 1 | 1 for pages larger than 512 bytes |
| size_log2 | input | 4 | Device capacity as log2 of MiB |
| row_addr | input | 24 | Page address |
| out_valid | output | 1 | Byte on out_byte is offered |
| out_ready | input | 1 | Downstream accepts the offered byte |
| out_byte | output | 8 | Address byte |
| out_last | output | 1 | Offered byte is the final one of the sequence |
| busy | output | 1 | A sequence is being emitted |
| done | output | 1 | One-clock pulse at the end of a sequence |

## Verification
The properties assume that out_ready may rise or fall in any cycle. They also assume that start, which may be high while busy, is otherwise a single-cycle pulse whose fields are valid only in that cycle. The bench drives a random ready value in every cycle. It only pulses start while the block is idle, except for deliberate pulses during busy with different fields, which check that such a request is dropped. Request fields are random across all size codes and both page types, and directed cases sit on each capacity threshold and on the empty request.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

  typedef logic [2:0] cyc_t;

  // Zero-valued column cycles needed for a page-aligned access.
  function automatic cyc_t col_cycles(input logic col_en, input logic big_page);
    if (!col_en)      return 3'd0;
    else if (big_page) return 3'd2;
    else               return 3'd1;
  endfunction

  // Row cycles: a third byte is added at or above the page-type threshold.
  function automatic cyc_t row_cycles(input logic row_en, input logic big_page,
                                      input logic [3:0] size_log2,
                                      input logic [3:0] lp_min, input logic [3:0] sp_min,
                                      input int unsigned max_bytes);
    logic [3:0] thr;
    thr = big_page ? lp_min : sp_min;
    if (!row_en)            return 3'd0;
    else if (size_log2 >= thr) return cyc_t'(max_bytes);
    else                    return cyc_t'(max_bytes - 1);
  endfunction

endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
  import nand_addr_pkg::*;
#(
  parameter int SIZE_W    = 4,
  parameter int LP_MIN    = 8,
  parameter int SP_MIN    = 6,
  parameter int ROW_BYTES = 3
) (
  input  logic              col_en,
  input  logic              row_en,
  input  logic              big_page,
  input  logic [SIZE_W-1:0] size_log2,
  output cyc_t              n_col,
  output cyc_t              n_total
);
  cyc_t n_row;

  always_comb begin
    n_col   = col_cycles(col_en, big_page);
    n_row   = row_cycles(row_en, big_page, 4'(size_log2), 4'(LP_MIN), 4'(SP_MIN),
                         ROW_BYTES);
    n_total = n_col + n_row;
  end
endmodule

// File: rtl/nand_addr_pick.sv
module nand_addr_pick
  import nand_addr_pkg::*;
#(
  parameter int ROW_W = 24
) (
  input  cyc_t             idx,
  input  cyc_t             n_col,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       byte_o,
  output logic             is_col
);
  localparam int LANES = ROW_W / 8;

  logic [7:0] lane [LANES];
  cyc_t       sel;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = row[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    is_col = (idx < n_col);
    sel    = idx - n_col;
    byte_o = 8'h00;
    if (!is_col) begin
      for (int i = 0; i < LANES; i++)
        if (sel == cyc_t'(i)) byte_o = lane[i];
    end
  end
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  cyc_t req_total,
  input  logic out_ready,
  output logic busy,
  output cyc_t idx,
  output cyc_t len,
  output logic last,
  output logic fire,
  output logic done
);
  assign last = busy && (idx == len - 3'd1);
  assign fire = busy && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      len  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        idx  <= '0;
        len  <= req_total;
        busy <= (req_total != 3'd0);
        done <= (req_total == 3'd0);
      end else if (fire) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_addr_pkg::*;
#(
  parameter int SIZE_W = 4,
  parameter int ROW_W  = 24,
  parameter int LP_MIN = 8,
  parameter int SP_MIN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_en,
  input  logic              row_en,
  input  logic              big_page,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic [ROW_W-1:0]  row_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last,
  output logic              busy,
  output logic              done
);
  localparam int ROW_BYTES = ROW_W / 8;

  cyc_t             req_col, req_total;
  cyc_t             col_q, idx, len;
  logic [ROW_W-1:0] row_q;
  logic             seq_last, seq_fire, is_col;

  // Named events for the checker.
  logic start_taken, start_empty, hs_fire, hs_final;
  assign start_taken = start && !busy;
  assign start_empty = start_taken && (req_total == 3'd0);
  assign hs_fire     = seq_fire;
  assign hs_final    = seq_fire && seq_last;

  nand_addr_plan #(.SIZE_W(SIZE_W), .LP_MIN(LP_MIN), .SP_MIN(SP_MIN),
                   .ROW_BYTES(ROW_BYTES)) u_plan (
    .col_en(col_en), .row_en(row_en), .big_page(big_page),
    .size_log2(size_log2), .n_col(req_col), .n_total(req_total)
  );

  nand_addr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_taken), .req_total(req_total),
    .out_ready(out_ready), .busy(busy), .idx(idx), .len(len),
    .last(seq_last), .fire(seq_fire), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (start_taken) begin
      col_q <= req_col;
      row_q <= row_addr;
    end
  end

  nand_addr_pick #(.ROW_W(ROW_W)) u_pick (
    .idx(idx), .n_col(col_q), .row(row_q), .byte_o(out_byte), .is_col(is_col)
  );

  assign out_valid = busy;
  assign out_last  = seq_last;
endmodule

// File: rtl/nand_addr_gen_chk.sv
module nand_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last,
  input logic       done,
  input logic       is_col,
  input logic       start_empty,
  input logic       hs_final,
  input logic [2:0] len
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid && !done);

  a_r2_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_col |-> out_byte == 8'h00);

  a_r7_last_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r8_empty_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    start_empty |=> done && !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  a_r10_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    hs_final |=> done && !out_valid);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && !hs_final |=> out_valid && $stable(len));
endmodule

bind nand_addr_gen nand_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last), .done(done),
  .is_col(is_col), .start_empty(start_empty), .hs_final(hs_final), .len(len)
);

// File: tb/nand_addr_gen_test.sv
module nand_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, col_en = 1'b0, row_en = 1'b0, big_page = 1'b0;
  logic [3:0]  size_log2 = '0;
  logic [23:0] row_addr = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_last, busy, done;
  logic [7:0]  out_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit wd_hit   = 1'b0;

  always #10 clk = ~clk;

  nand_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .col_en(col_en), .row_en(row_en),
    .big_page(big_page), .size_log2(size_log2), .row_addr(row_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent restatement of the byte plan.
  function automatic int ref_cols(bit c, bit big);
    if (!c) return 0;
    return big ? 2 : 1;
  endfunction

  function automatic int ref_rows(bit r, bit big, int sz);
    longint mib;
    if (!r) return 0;
    mib = longint'(1) << sz;
    if (mib >= (big ? 256 : 64)) return 3;
    return 2;
  endfunction

  function automatic logic [7:0] ref_byte(int k, int nc, logic [23:0] ra);
    if (k < nc) return 8'h00;
    return 8'((ra >> (8 * (k - nc))) & 24'hFF);
  endfunction

  // ready_mode: 0 random, 1 always ready; poke: inject a start while busy.
  task automatic run(input bit c, input bit r, input bit big, input int sz,
                     input logic [23:0] ra, input int ready_mode, input bit poke);
    int nc, nt, k, cyc;
    bit fin, stalled, poked;
    logic [7:0] held_b;
    logic held_l;
    nc = ref_cols(c, big);
    nt = nc + ref_rows(r, big, sz);
    col_en = c; row_en = r; big_page = big; size_log2 = 4'(sz); row_addr = ra;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; col_en = $urandom; row_en = $urandom; row_addr = $urandom;
    k = 0; fin = 0; stalled = 0; poked = 0; held_b = '0; held_l = 0;
    if (nt == 0) begin
      check("R8 done", 32'(done), 1);
      check("R8 no byte", 32'(out_valid), 0);
      out_ready = 1'b0;
      @(negedge clk);
      check("R10 done width", 32'(done), 0);
      return;
    end
    for (cyc = 0; cyc < 60 && !fin; cyc++) begin
      start = 1'b0;
      if (k == nt) begin
        check("R10 done after final", 32'(done), 1);
        check("R10 idle at done", 32'(out_valid), 0);
        fin = 1;
      end else begin
        check("R10 no early done", 32'(done), 0);
        check("R2/R3 valid", 32'(out_valid), 1);
        if (stalled) begin
          check("R9 hold byte", 32'(out_byte), 32'(held_b));
          check("R9 hold last", 32'(out_last), 32'(held_l));
        end
        if (k < nc) check("R2 column byte", 32'(out_byte), 0);
        else check("R3 row byte", 32'(out_byte), 32'(ref_byte(k, nc, ra)));
        if (!r) check("R6 last marker", 32'(out_last), 32'(k == nt - 1));
        else    check("R7 last marker", 32'(out_last), 32'(k == nt - 1));
        out_ready = (ready_mode == 1) ? 1'b1 : 1'($urandom);
        if (poke && !poked && k == 0) begin
          // R11: a new request during busy must be dropped
          start = 1'b1; col_en = 1'b0; row_en = 1'b0; poked = 1;
        end
        held_b = out_byte; held_l = out_last;
        stalled = !out_ready;
        if (out_ready) k++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R4/R5 byte count", 32'(k), 32'(nt));
    out_ready = 1'b0;
    @(negedge clk);
    check("R10 single done", 32'(done), 0);
  endtask

  initial begin
    #4_000_000;
    wd_hit = 1'b1;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(out_valid), 0);
    check("R1 last", 32'(out_last), 0);
    check("R1 done", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Threshold corners (R4, R5)
    run(1, 1, 1, 7, 24'hA1B2C3, 1, 0);
    run(1, 1, 1, 8, 24'hA1B2C3, 1, 0);
    run(1, 1, 0, 5, 24'h123456, 1, 0);
    run(1, 1, 0, 6, 24'h123456, 1, 0);
    // Column only (R6), row only, empty (R8)
    run(1, 0, 0, 9, 24'hFFFFFF, 1, 0);
    run(1, 0, 1, 9, 24'hFFFFFF, 0, 0);
    run(0, 1, 1, 10, 24'h00FF00, 0, 0);
    run(0, 0, 1, 10, 24'h000000, 1, 0);
    run(0, 0, 0, 2, 24'h000000, 0, 0);
    // Start while busy (R11)
    run(1, 1, 1, 12, 24'h5A6B7C, 0, 1);
    run(0, 1, 0, 6, 24'hC0FFEE, 1, 1);
    for (int t = 0; t < 300 && !wd_hit; t++)
      run($urandom, $urandom, $urandom, $urandom_range(0, 15), $urandom,
          $urandom_range(0, 1), ($urandom_range(0, 7) == 0));
    if (wd_hit) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=expired expected=complete");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule